// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block turns the two oversampled data lines of a low-speed USB link into a stream of received bytes. It is armed by a single-clock wake pulse, after which it hunts for the start of a packet. It locks onto the first idle-to-K transition of D-, confirms the start of the packet once it sees the double-K that ends the sync field, and then takes one sample near the centre of every bit. Each level change on D- pulls the sample point back into line, so a link whose bit clock is slightly off the local reference is still sampled near mid-bit.

Samples are NRZI-decoded. Inserted stuff bits are removed, and the data bits are packed LSb first into bytes. Each byte is presented with a one-clock strobe. The packet ends on a single-ended-zero condition, a stuff violation or a buffer overrun. Each of these raises its own one-clock flag and returns the block to idle, where it waits for the next wake. If no start edge arrives soon enough after the wake, the block reports a sync timeout and receives nothing.

Top module: `usbls_rx`

## Requirements
- R1: While reset is held, and in the clock after it is released, rx_valid, rx_eop, rx_overflow, rx_sync_to and rx_stuff_err are all low.
- R2: After rx_wake, a falling edge on line_dm (J to K) starts a start check. Reception begins only if line_dm is also low at the sample one bit later. If it is high there, the block goes back to hunting for the next falling edge.
- R3: If no falling edge on line_dm is seen in the SYNC_WAIT clocks spent hunting after rx_wake, rx_sync_to pulses exactly SYNC_WAIT clocks after the clock that took the wake. The block returns to idle and delivers no bytes.
- R4: Each bit is sampled BIT_CLKS/2 clocks after the latest line_dm transition or nominal bit boundary. Because the phase restarts at every line_dm transition, bit lengths of BIT_CLKS±1 clocks, with a bounded running drift, are received correctly.
- R5: NRZI decoding: a sample at the same line_dm level as the previous one is a 1, and a change is a 0. The first data bit is compared with the K that ends the sync field.
- R6: The count of consecutive 1 data bits starts at zero after sync. After six 1s in a row, the next bit is a stuffed bit: a 0 there is dropped and never reaches a byte.
- R7: A 1 in the stuffed-bit position pulses rx_stuff_err and aborts the packet. No further byte, rx_eop or rx_overflow follows until the next wake.
- R8: Data bits fill each byte from bit 0 (first received) to bit 7. rx_valid is high for exactly one clock per completed byte, with the byte on rx_byte.
- R9: End of packet is declared when line_dm is low at two successive samples and line_dp was low at the bit boundary before the second of them. rx_eop then pulses once, a partly filled byte is discarded, and the block goes idle.
- R10: Two successive K samples (line_dm low, line_dp high) are data 1 bits and never an end of packet.
- R11: At most RX_LIMIT bytes are delivered per packet. When byte RX_LIMIT+1 completes, rx_overflow pulses in place of rx_valid and the packet is aborted, so no rx_eop follows.
- R12: rx_valid, rx_eop, rx_overflow, rx_sync_to and rx_stuff_err are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, about BIT_CLKS per line bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rx_wake | input | 1 | One-clock pulse that arms the receiver from idle |
| line_dp | input | 1 | D+ line level, already synchronous to clk |
| line_dm | input | 1 | D- line level, already synchronous to clk (1 = J) |
| rx_byte | output | 8 | Last completed byte |
| rx_valid | output | 1 | One-clock strobe per completed byte |
| rx_eop | output | 1 | One-clock pulse on end of packet |
| rx_overflow | output | 1 | One-clock pulse when the byte limit is exceeded |
| rx_sync_to | output | 1 | One-clock pulse when no start edge arrives in time |
| rx_stuff_err | output | 1 | One-clock pulse on a stuff-bit violation |

## Verification
Line inputs pass through one register, and a bit is acted on BIT_CLKS/2 clocks after its first edge. A byte strobe therefore follows the middle of the byte's last bit by one clock, and rx_eop comes one clock after the second single-ended-zero sample. That is between 2 and 2*BIT_CLKS+2 clocks after the bench drives the single-ended zero, and the bench checks rx_eop against this window. The sync timeout has an exact due time of SYNC_WAIT clocks after the clock that took the wake, and the bench checks that count exactly. The bench samples every output on the falling clock edge, logs strobes with their cycle numbers, and compares the byte order, contents and flag counts against values computed from the bytes it encoded, once the line has returned to idle.

// File: rtl/usbls_rx_pkg.sv
package usbls_rx_pkg;
  // Receiver sequencing states
  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_HUNT    = 2'd1,
    RX_CONFIRM = 2'd2,
    RX_RECV    = 2'd3
  } rx_state_e;

  localparam int unsigned RX_BYTE_W    = 8;
  localparam int unsigned RX_STUFF_RUN = 6;
endpackage

// File: rtl/usbls_line_sampler.sv
// Registers the line, tracks bit phase from D- transitions and produces
// the mid-bit sample strobe and the D+ level seen at each bit boundary.
module usbls_line_sampler #(
  parameter int unsigned BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_in,
  input  logic dm_in,
  output logic dm_s,
  output logic dm_fall,
  output logic sample_stb,
  output logic dp_bnd_low
);
  localparam int unsigned CW = $clog2(BIT_CLKS);
  localparam logic [CW-1:0] HALF = CW'(BIT_CLKS / 2);
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic          dp_s;
  logic          dm_prev;
  logic [CW-1:0] phase_q, phase_d;
  logic          dm_edge;
  logic          bnd_stb;
  logic          bnd_low_q;

  assign dm_edge    = dm_s ^ dm_prev;
  assign dm_fall    = dm_edge & ~dm_s;
  assign bnd_stb    = dm_edge | (phase_q == '0);
  assign sample_stb = (phase_q == HALF);
  assign dp_bnd_low = bnd_low_q;

  always_comb begin
    if (dm_edge) begin
      phase_d = CW'(1);
    end else if (phase_q == LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_s      <= 1'b0;
      dm_s      <= 1'b1;
      dm_prev   <= 1'b1;
      phase_q   <= '0;
      bnd_low_q <= 1'b0;
    end else begin
      dp_s    <= dp_in;
      dm_s    <= dm_in;
      dm_prev <= dm_s;
      phase_q <= phase_d;
      if (bnd_stb) begin
        bnd_low_q <= ~dp_s;
      end
    end
  end
endmodule

// File: rtl/usbls_unstuff.sv
// Removes the stuffed bit after a run of ones and flags a violating one.
module usbls_unstuff #(
  parameter int unsigned RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_val,
  output logic out_vld,
  output logic out_bit,
  output logic stuff_err
);
  localparam int unsigned OW = $clog2(RUN + 1);
  localparam logic [OW-1:0] RUN_END = OW'(RUN);

  logic [OW-1:0] ones_q, ones_d;
  logic          at_run;

  assign at_run    = (ones_q == RUN_END);
  assign out_vld   = bit_vld & ~at_run;
  assign out_bit   = bit_val;
  assign stuff_err = bit_vld & at_run & bit_val;

  always_comb begin
    ones_d = ones_q;
    if (clr) begin
      ones_d = '0;
    end else if (bit_vld) begin
      if (at_run || !bit_val) begin
        ones_d = '0;
      end else begin
        ones_d = ones_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else begin
      ones_q <= ones_d;
    end
  end
endmodule

// File: rtl/usbls_byte_packer.sv
// Packs data bits LSb first and enforces the per-packet byte budget.
module usbls_byte_packer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LIMIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_stb,
  output logic              ovf_stb
);
  localparam int unsigned BCW = $clog2(BYTE_W);
  localparam int unsigned LW  = $clog2(LIMIT + 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(BYTE_W - 1);
  localparam logic [LW-1:0]  BUDGET_IV = LW'(LIMIT);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic [LW-1:0]     budget_q, budget_d;
  logic [BYTE_W-1:0] merged;
  logic              done;
  logic              byte_en;
  logic              stb_d, ovf_d;

  assign merged  = {bit_val, sh_q[BYTE_W-1:1]};
  assign done    = bit_vld & (bcnt_q == BIT_LAST);
  assign byte_en = done & (budget_q != '0) & ~clr;

  always_comb begin
    sh_d     = sh_q;
    bcnt_d   = bcnt_q;
    budget_d = budget_q;
    stb_d    = 1'b0;
    ovf_d    = 1'b0;
    if (clr) begin
      sh_d     = '0;
      bcnt_d   = '0;
      budget_d = BUDGET_IV;
    end else if (bit_vld) begin
      sh_d   = merged;
      bcnt_d = done ? '0 : bcnt_q + 1'b1;
      if (done) begin
        if (budget_q == '0) begin
          ovf_d = 1'b1;
        end else begin
          stb_d    = 1'b1;
          budget_d = budget_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bcnt_q   <= '0;
      budget_q <= BUDGET_IV;
      byte_stb <= 1'b0;
      ovf_stb  <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      bcnt_q   <= bcnt_d;
      budget_q <= budget_d;
      byte_stb <= stb_d;
      ovf_stb  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= merged;
    end
  end
endmodule

// File: rtl/usbls_rx.sv
// Low-speed packet receiver: sync hunt, start check, NRZI decode,
// unstuffing, byte packing, end-of-packet and abort handling.
module usbls_rx
  import usbls_rx_pkg::*;
#(
  parameter int unsigned BIT_CLKS  = 8,
  parameter int unsigned SYNC_WAIT = 32,
  parameter int unsigned RX_LIMIT  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_wake,
  input  logic                 line_dp,
  input  logic                 line_dm,
  output logic [RX_BYTE_W-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_eop,
  output logic                 rx_overflow,
  output logic                 rx_sync_to,
  output logic                 rx_stuff_err
);
  localparam int unsigned HW = $clog2(SYNC_WAIT + 1);
  localparam logic [HW-1:0] HUNT_LAST = HW'(SYNC_WAIT - 1);

  rx_state_e     state, state_d;
  logic [HW-1:0] hunt_q, hunt_d;
  logic          conf_q, conf_d;
  logic          lvl_q, lvl_d;
  logic          eop_q, eop_d;
  logic          to_q, to_d;
  logic          serr_q, serr_d;

  logic dm_s, dm_fall, sample_stb, dp_bnd_low;
  logic recv_smp, se0, nrzi_bit, bit_vld, in_recv_n;
  logic data_vld, data_bit, stuff_err;

  usbls_line_sampler #(.BIT_CLKS(BIT_CLKS)) u_smp (
    .clk        (clk),
    .rst_n      (rst_n),
    .dp_in      (line_dp),
    .dm_in      (line_dm),
    .dm_s       (dm_s),
    .dm_fall    (dm_fall),
    .sample_stb (sample_stb),
    .dp_bnd_low (dp_bnd_low)
  );

  assign recv_smp  = (state == RX_RECV) & sample_stb;
  assign se0       = ~dm_s & ~lvl_q & dp_bnd_low;
  assign nrzi_bit  = (dm_s == lvl_q);
  assign bit_vld   = recv_smp & ~se0;
  assign in_recv_n = (state != RX_RECV);

  usbls_unstuff #(.RUN(RX_STUFF_RUN)) u_unstuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (in_recv_n),
    .bit_vld   (bit_vld),
    .bit_val   (nrzi_bit),
    .out_vld   (data_vld),
    .out_bit   (data_bit),
    .stuff_err (stuff_err)
  );

  usbls_byte_packer #(.BYTE_W(RX_BYTE_W), .LIMIT(RX_LIMIT)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (in_recv_n),
    .bit_vld  (data_vld),
    .bit_val  (data_bit),
    .byte_q   (rx_byte),
    .byte_stb (rx_valid),
    .ovf_stb  (rx_overflow)
  );

  always_comb begin
    state_d = state;
    hunt_d  = hunt_q;
    conf_d  = conf_q;
    lvl_d   = lvl_q;
    eop_d   = 1'b0;
    to_d    = 1'b0;
    serr_d  = 1'b0;
    unique case (state)
      RX_IDLE: begin
        if (rx_wake) begin
          state_d = RX_HUNT;
          hunt_d  = '0;
        end
      end
      RX_HUNT: begin
        if (dm_fall) begin
          state_d = RX_CONFIRM;
          conf_d  = 1'b0;
        end else if (hunt_q == HUNT_LAST) begin
          state_d = RX_IDLE;
          to_d    = 1'b1;
        end else begin
          hunt_d = hunt_q + 1'b1;
        end
      end
      RX_CONFIRM: begin
        if (sample_stb) begin
          if (dm_s) begin
            state_d = RX_HUNT;
          end else if (conf_q) begin
            state_d = RX_RECV;
            lvl_d   = 1'b0;
          end else begin
            conf_d = 1'b1;
          end
        end
      end
      RX_RECV: begin
        if (rx_overflow) begin
          state_d = RX_IDLE;
        end else if (recv_smp) begin
          lvl_d = dm_s;
          if (se0) begin
            state_d = RX_IDLE;
            eop_d   = 1'b1;
          end else if (stuff_err) begin
            state_d = RX_IDLE;
            serr_d  = 1'b1;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      hunt_q <= '0;
      conf_q <= 1'b0;
      lvl_q  <= 1'b0;
      eop_q  <= 1'b0;
      to_q   <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      state  <= state_d;
      hunt_q <= hunt_d;
      conf_q <= conf_d;
      lvl_q  <= lvl_d;
      eop_q  <= eop_d;
      to_q   <= to_d;
      serr_q <= serr_d;
    end
  end

  assign rx_eop       = eop_q;
  assign rx_sync_to   = to_q;
  assign rx_stuff_err = serr_q;
endmodule

// File: rtl/usbls_rx_chk.sv
module usbls_rx_chk
  import usbls_rx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      rx_valid,
  input logic      rx_eop,
  input logic      rx_overflow,
  input logic      rx_sync_to,
  input logic      rx_stuff_err,
  input rx_state_e st
);
  // R12
  pulses_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_eop, rx_overflow, rx_sync_to, rx_stuff_err}));

  // R8
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  byte_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(st) == RX_RECV);

  // R9
  eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |-> (st == RX_IDLE) && ($past(st) == RX_RECV));

  // R3
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync_to |-> (st == RX_IDLE) && ($past(st) == RX_HUNT));

  // R11
  ovf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> (st == RX_IDLE) && !rx_eop);

  // R7
  stuff_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> (st == RX_IDLE) && !rx_valid);
endmodule

bind usbls_rx usbls_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_eop       (rx_eop),
  .rx_overflow  (rx_overflow),
  .rx_sync_to   (rx_sync_to),
  .rx_stuff_err (rx_stuff_err),
  .st           (state)
);

// File: tb/tb_usbls_rx.sv
`timescale 1ns/1ps
module tb_usbls_rx;
  localparam int BIT_CLKS  = 8;
  localparam int SYNC_WAIT = 32;
  localparam int RX_LIMIT  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, rx_wake, line_dp, line_dm;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_eop, rx_overflow, rx_sync_to, rx_stuff_err;

  usbls_rx #(.BIT_CLKS(BIT_CLKS), .SYNC_WAIT(SYNC_WAIT), .RX_LIMIT(RX_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .rx_wake(rx_wake), .line_dp(line_dp), .line_dm(line_dm),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_overflow(rx_overflow),
    .rx_sync_to(rx_sync_to), .rx_stuff_err(rx_stuff_err)
  );

  int     checks = 0;
  int     fails  = 0;
  bit     done   = 1'b0;
  longint cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, sampled away from the active edge
  logic [7:0] got[$];
  int     n_eop, n_ovf, n_to, n_serr, n_multi;
  longint eop_cyc, to_cyc, wake_cyc, se0_cyc;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) got.push_back(rx_byte);
      if (rx_eop) begin n_eop++; eop_cyc = cyc; end
      if (rx_overflow) n_ovf++;
      if (rx_sync_to) begin n_to++; to_cyc = cyc; end
      if (rx_stuff_err) n_serr++;
      if (32'(rx_valid) + 32'(rx_eop) + 32'(rx_overflow) + 32'(rx_sync_to) + 32'(rx_stuff_err) > 1)
        n_multi++;
    end
  end

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input string what, input longint act, input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // Line encoding helpers
  logic [7:0] pkt[$];
  bit         xbits[$];
  int         dev = 0;

  task automatic drive_bit(input bit dp, input bit dm, input bit jit);
    int step;
    step = 0;
    if (jit) begin
      step = int'($urandom_range(0, 2)) - 1;
      if (dev + step > 1 || dev + step < -1) step = 0;
      dev += step;
    end
    line_dp = dp;
    line_dm = dm;
    repeat (BIT_CLKS + step) @(negedge clk);
  endtask

  task automatic put_nrzi(inout bit lvl, inout int ones, input bit v, input bit stuff_on, input bit jit);
    if (!v) lvl = ~lvl;
    drive_bit(~lvl, lvl, jit);
    ones = v ? ones + 1 : 0;
    if (stuff_on && ones == 6) begin
      lvl = ~lvl;
      drive_bit(~lvl, lvl, jit);
      ones = 0;
    end
  endtask

  task automatic send_frame(input bit stuff_on, input bit jit);
    bit sync_dm[8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    bit lvl;
    int ones;
    dev = 0;
    foreach (sync_dm[i]) drive_bit(~sync_dm[i], sync_dm[i], jit);
    lvl  = 1'b0;
    ones = 0;
    foreach (pkt[i])
      for (int b = 0; b < 8; b++) put_nrzi(lvl, ones, pkt[i][b], stuff_on, jit);
    foreach (xbits[i]) put_nrzi(lvl, ones, xbits[i], stuff_on, jit);
    se0_cyc = cyc;
    drive_bit(1'b0, 1'b0, 1'b0);
    drive_bit(1'b0, 1'b0, 1'b0);
    line_dp = 1'b0;
    line_dm = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic clear_mon();
    got.delete();
    n_eop = 0; n_ovf = 0; n_to = 0; n_serr = 0;
  endtask

  task automatic wake_up();
    rx_wake = 1'b1;
    @(negedge clk);
    wake_cyc = cyc;
    rx_wake = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_pkt(input string req, input bit stuff_on, input bit jit, input int exp_n,
                         input bit exp_eop, input bit exp_ovf, input bit exp_serr);
    clear_mon();
    wake_up();
    send_frame(stuff_on, jit);
    chk_eq(req, "byte count", got.size(), exp_n);
    for (int i = 0; i < exp_n; i++)
      chk_eq(req, $sformatf("byte %0d", i), (i < got.size()) ? longint'(got[i]) : -1, pkt[i]);
    chk_eq(exp_eop ? "R9" : "R7/R11", "eop count", n_eop, exp_eop);
    chk_eq("R11", "overflow count", n_ovf, exp_ovf);
    chk_eq("R7", "stuff error count", n_serr, exp_serr);
    chk_eq("R2", "no timeout", n_to, 0);
    if (exp_eop) chk_win("R9", "eop delay", eop_cyc - se0_cyc, 2, 2 * BIT_CLKS + 2);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; rx_wake = 1'b0; line_dp = 1'b0; line_dm = 1'b1;
    n_multi = 0;
    clear_mon();
    repeat (5) @(negedge clk);
    // R1 reset state
    chk_eq("R1", "outputs in reset",
           {rx_valid, rx_eop, rx_overflow, rx_sync_to, rx_stuff_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "outputs after reset",
           {rx_valid, rx_eop, rx_overflow, rx_sync_to, rx_stuff_err}, 0);
    repeat (4) @(negedge clk);

    // R3 sync timeout with an idle line
    clear_mon();
    rx_wake = 1'b1;
    @(negedge clk);
    wake_cyc = cyc;
    rx_wake = 1'b0;
    repeat (SYNC_WAIT + 10) @(negedge clk);
    chk_eq("R3", "timeout count", n_to, 1);
    chk_eq("R3", "timeout delay", to_cyc - wake_cyc, SYNC_WAIT);
    chk_eq("R3", "no bytes", got.size(), 0);

    // R2 single K then idle: start check fails, hunting resumes, then times out
    clear_mon();
    wake_up();
    drive_bit(1'b1, 1'b0, 1'b0);
    line_dp = 1'b0; line_dm = 1'b1;
    repeat (SYNC_WAIT + 3 * BIT_CLKS) @(negedge clk);
    chk_eq("R2", "false start timeout", n_to, 1);
    chk_eq("R2", "false start bytes", got.size(), 0);
    chk_eq("R2", "false start eop", n_eop, 0);

    // R5 R8 R9 basic packet
    pkt = '{8'hA5, 8'h3C}; xbits.delete();
    run_pkt("R5/R8", 1'b1, 1'b0, 2, 1'b1, 1'b0, 1'b0);

    // R6 R10 long runs of ones with stuffing
    pkt = '{8'hFF, 8'hFF, 8'hFF}; xbits.delete();
    run_pkt("R6/R10", 1'b1, 1'b0, 3, 1'b1, 1'b0, 1'b0);

    // R4 jittered bit lengths
    pkt = '{8'h00, 8'hFF, 8'h7E, 8'h81, 8'h3F}; xbits.delete();
    run_pkt("R4", 1'b1, 1'b1, 5, 1'b1, 1'b0, 1'b0);

    // R9 partial byte discarded
    pkt = '{8'h5A}; xbits = '{1'b1, 1'b0, 1'b1};
    run_pkt("R9", 1'b1, 1'b0, 1, 1'b1, 1'b0, 1'b0);

    // R9 R10 empty packet right after sync
    pkt.delete(); xbits.delete();
    run_pkt("R9/R10", 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b0);

    // R7 missing stuff bit
    pkt = '{8'hFF, 8'h12}; xbits.delete();
    run_pkt("R7", 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1);

    // R11 one byte over the limit
    pkt.delete(); xbits.delete();
    for (int i = 0; i <= RX_LIMIT; i++) pkt.push_back(8'(8'h11 * (i + 1)));
    run_pkt("R11", 1'b1, 1'b0, RX_LIMIT, 1'b0, 1'b1, 1'b0);

    // R8 random packets, some with jitter
    for (int k = 0; k < 8; k++) begin
      int n;
      n = int'($urandom_range(1, RX_LIMIT));
      pkt.delete(); xbits.delete();
      for (int i = 0; i < n; i++) pkt.push_back(8'($urandom_range(0, 255)));
      run_pkt("R8", 1'b1, k[0], n, 1'b1, 1'b0, 1'b0);
    end

    // R12 status pulses never overlap
    chk_eq("R12", "overlapping pulses", n_multi, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule